// File: doc/BRIEF.md
# Suffix Constant and Register Operand Decoder

This block turns one instruction word into the two source operands it names. Each operand comes out either as a register index for the register file or as a resolved 64-bit constant. Two register specifiers never reach the register file. Specifier 63 stands for the constant zero and specifier 62 stands for the current instruction pointer. Both are resolved here so that later stages see a ready value.

Immediate-form instructions carry a 28-bit immediate. Without help, that immediate is sign-extended. When the instruction sets its suffix flag, the following word on the same cache line supplies the upper 36 bits, which gives a full 64-bit constant. This costs no extra instruction slot and no extra cycle. If that following word has not arrived yet, the block raises a stall. A suffix word found on its own at an instruction slot decodes as a no-op.

All results are registered once, at the clock edge that ends the decode cycle in which the inputs were presented.

Top module: `suffix_opdec`

## Requirements
- R1: While `rst_n` is low, every output reads zero at the next clock edge, whatever the inputs are.
- R2: A register-form word (tag bits [39:36] neither 4'hE nor 4'hF) with first specifier in bits [35:30] and second specifier in bits [29:24] both below 62 reports each specifier as a register index, with `*_is_const` low and `*_value` zero.
- R3: Specifier 63 in either source position resolves to a constant: `*_is_const` is high, the index is zero and the value is zero.
- R4: Specifier 62 in either source position resolves to a constant whose value is the `cur_ip` presented with the word.
- R5: An immediate-form word (tag 4'hE, suffix flag at bit 28 clear, immediate in bits [27:0]) yields operand B as a constant equal to the immediate sign-extended from bit 27 to 64 bits.
- R6: An immediate-form word with the suffix flag set, together with a valid next word whose tag bits [39:36] are 4'hF, yields operand B = {next word bits [35:0], immediate[27:0]}, and `sfx_used` is high.
- R7: An immediate-form word with the suffix flag set while `next_valid` is low yields `dec_stall` high and `dec_valid` low, with all operand outputs zero.
- R8: A word whose tag is 4'hF decodes as a no-op: `dec_valid` and `dec_nop` are high, and neither operand is reported as a constant or carries a nonzero index or value.
- R9: If the suffix flag is set and the next word is valid but its tag is not 4'hF, operand B falls back to the sign-extended immediate, `sfx_used` stays low and no stall is raised.
- R10: With the suffix flag clear, the next word has no effect on the result even when it is valid and carries the suffix tag; `sfx_used` stays low.
- R11: The result of the inputs sampled at one clock edge appears on the outputs right after that edge; with `in_valid` low, `dec_valid`, `dec_nop`, `dec_stall` and `sfx_used` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| inst_word | input | 40 | Instruction word at the current slot |
| next_word | input | 40 | Word following the current slot on the cache line |
| next_valid | input | 1 | `next_word` holds fetched data |
| cur_ip | input | 64 | Instruction pointer of the current slot |
| dec_valid | output | 1 | A decoded result is present |
| dec_nop | output | 1 | The slot held a lone suffix word |
| dec_stall | output | 1 | Suffix required but the next word is not available |
| sfx_used | output | 1 | The next word was consumed as a constant suffix |
| opa_is_const | output | 1 | Operand A is a constant, not a register |
| opa_reg | output | 6 | Operand A register index |
| opa_value | output | 64 | Operand A constant value |
| opb_is_const | output | 1 | Operand B is a constant, not a register |
| opb_reg | output | 6 | Operand B register index |
| opb_value | output | 64 | Operand B constant value |

## Verification
The hardest situations to reach are the ones where the suffix flag and the next word disagree. One case is a valid next word that carries a different tag. Another is a next word that carries the suffix tag while the flag is clear. The third is a flag that is set while the next word has not arrived. In normal code none of these occurs, because a well-formed stream always pairs a flagged word with its suffix. The stimulus therefore drives `next_word` and `next_valid` independently of `inst_word`, building each of the three mismatched pairings on purpose. It also places a lone suffix word at a slot, and it combines a widened immediate with the pointer specifier in the same word, so that both constant paths resolve in one cycle.

// File: rtl/suffix_opdec_pkg.sv
// Shared widths, field codes and result types for the operand decoder.
// Assumes one suffix word exactly fills the missing upper constant bits.
package suffix_opdec_pkg;
    parameter int XLEN     = 64;
    parameter int SPEC_W   = 6;
    parameter int IMM_W    = 28;
    parameter int TAG_W    = 4;
    parameter int NUM_SRC  = 2;
    localparam int HI_W    = XLEN - IMM_W;
    localparam int WORD_W  = TAG_W + HI_W;
    localparam logic [TAG_W-1:0]  TAG_SFX   = 4'hF;
    localparam logic [TAG_W-1:0]  TAG_IMM   = 4'hE;
    localparam logic [SPEC_W-1:0] SPEC_ZERO = 6'd63;
    localparam logic [SPEC_W-1:0] SPEC_IP   = 6'd62;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_IMM = 2'd1,
        K_SFX = 2'd2
    } word_kind_t;

    typedef struct packed {
        logic              is_const;
        logic [SPEC_W-1:0] idx;
        logic [XLEN-1:0]   value;
    } src_t;

    typedef struct packed {
        logic valid;
        logic nop;
        logic stall;
        logic sfx_used;
        src_t a;
        src_t b;
    } dec_t;
endpackage

// File: rtl/suffix_opdec_split.sv
// Splits an instruction word into its kind and raw fields.
// Assumes the tag sits in the top bits and both specifiers follow it;
// register-form and immediate-form words share the same bit positions.
module suffix_opdec_split
    import suffix_opdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_kind_t        kind,
    output logic [SPEC_W-1:0] spec_a,
    output logic [SPEC_W-1:0] spec_b,
    output logic              sfx_flag,
    output logic [IMM_W-1:0]  imm
);
    localparam int TAG_LSB = WORD_W - TAG_W;
    localparam int RA_LSB  = TAG_LSB - SPEC_W;
    localparam int RB_LSB  = RA_LSB - SPEC_W;

    logic [TAG_W-1:0] tag;

    // Classify the word from its tag and pull out the fixed fields.
    always_comb begin
        tag      = word[TAG_LSB +: TAG_W];
        spec_a   = word[RA_LSB +: SPEC_W];
        spec_b   = word[RB_LSB +: SPEC_W];
        sfx_flag = word[IMM_W];
        imm      = word[IMM_W-1:0];
        if (tag == TAG_SFX)      kind = K_SFX;
        else if (tag == TAG_IMM) kind = K_IMM;
        else                     kind = K_REG;
    end
endmodule

// File: rtl/suffix_opdec_srcsel.sv
// Resolves one register specifier into a register index or a constant.
// Specifier 63 reads as zero, specifier 62 reads as the instruction pointer.
// An inactive source reports neither an index nor a constant.
module suffix_opdec_srcsel
    import suffix_opdec_pkg::*;
(
    input  logic              active,
    input  logic [SPEC_W-1:0] spec,
    input  logic [XLEN-1:0]   ip,
    output src_t              src
);
    // Map the special specifiers to constants, pass the rest through.
    always_comb begin
        src = '0;
        if (active) begin
            if (spec == SPEC_ZERO) begin
                src.is_const = 1'b1;
            end else if (spec == SPEC_IP) begin
                src.is_const = 1'b1;
                src.value    = ip;
            end else begin
                src.idx = spec;
            end
        end
    end
endmodule

// File: rtl/suffix_opdec_widen.sv
// Builds the 64-bit immediate from the native field and an optional suffix.
// Assumes the suffix payload is exactly the width of the missing upper bits.
// The stall output is raw; the caller qualifies it with the word kind.
module suffix_opdec_widen
    import suffix_opdec_pkg::*;
(
    input  logic [IMM_W-1:0]  imm,
    input  logic              sfx_flag,
    input  logic [WORD_W-1:0] next_word,
    input  logic              next_valid,
    output logic [XLEN-1:0]   value,
    output logic              used,
    output logic              stall
);
    localparam int TAG_LSB = WORD_W - TAG_W;

    logic tag_ok;

    // Decide whether the next word is a usable suffix and form the constant.
    always_comb begin
        tag_ok = (next_word[TAG_LSB +: TAG_W] == TAG_SFX);
        stall  = sfx_flag & ~next_valid;
        used   = sfx_flag & next_valid & tag_ok;
        if (used) value = {next_word[HI_W-1:0], imm};
        else      value = {{HI_W{imm[IMM_W-1]}}, imm};
    end
endmodule

// File: rtl/suffix_opdec.sv
// Operand decoder top: resolves both source operands of one instruction
// and registers the result at the end of the decode cycle.
// Assumes the caller presents the word after the current slot on next_word.
module suffix_opdec
    import suffix_opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] inst_word,
    input  logic [WORD_W-1:0] next_word,
    input  logic              next_valid,
    input  logic [XLEN-1:0]   cur_ip,
    output logic              dec_valid,
    output logic              dec_nop,
    output logic              dec_stall,
    output logic              sfx_used,
    output logic              opa_is_const,
    output logic [SPEC_W-1:0] opa_reg,
    output logic [XLEN-1:0]   opa_value,
    output logic              opb_is_const,
    output logic [SPEC_W-1:0] opb_reg,
    output logic [XLEN-1:0]   opb_value
);
    word_kind_t        kind;
    logic [SPEC_W-1:0] spec [NUM_SRC];
    logic              active [NUM_SRC];
    src_t              src [NUM_SRC];
    logic              sfx_flag;
    logic [IMM_W-1:0]  imm;
    logic [XLEN-1:0]   imm_value;
    logic              imm_used;
    logic              imm_stall;
    dec_t              nxt;
    dec_t              q;

    suffix_opdec_split split_i (
        .word     (inst_word),
        .kind     (kind),
        .spec_a   (spec[0]),
        .spec_b   (spec[1]),
        .sfx_flag (sfx_flag),
        .imm      (imm)
    );

    suffix_opdec_widen widen_i (
        .imm        (imm),
        .sfx_flag   (sfx_flag),
        .next_word  (next_word),
        .next_valid (next_valid),
        .value      (imm_value),
        .used       (imm_used),
        .stall      (imm_stall)
    );

    // Source A is read by every non-suffix word; source B only by register form.
    always_comb begin
        active[0] = in_valid && (kind != K_SFX);
        active[1] = in_valid && (kind == K_REG);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        suffix_opdec_srcsel srcsel_i (
            .active (active[g]),
            .spec   (spec[g]),
            .ip     (cur_ip),
            .src    (src[g])
        );
    end

    // Combine kind, suffix state and resolved sources into the next result.
    always_comb begin
        nxt = '0;
        if (in_valid) begin
            if (kind == K_SFX) begin
                nxt.valid = 1'b1;
                nxt.nop   = 1'b1;
            end else if (kind == K_IMM && imm_stall) begin
                nxt.stall = 1'b1;
            end else begin
                nxt.valid = 1'b1;
                nxt.a     = src[0];
                if (kind == K_IMM) begin
                    nxt.b.is_const = 1'b1;
                    nxt.b.value    = imm_value;
                    nxt.sfx_used   = imm_used;
                end else begin
                    nxt.b = src[1];
                end
            end
        end
    end

    // Result register closing the decode cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // Drive the ports from the registered result.
    always_comb begin
        dec_valid    = q.valid;
        dec_nop      = q.nop;
        dec_stall    = q.stall;
        sfx_used     = q.sfx_used;
        opa_is_const = q.a.is_const;
        opa_reg      = q.a.idx;
        opa_value    = q.a.value;
        opb_is_const = q.b.is_const;
        opb_reg      = q.b.idx;
        opb_value    = q.b.value;
    end
endmodule

// File: rtl/suffix_opdec_chk.sv
// Property checker for the operand decoder, attached through bind.
module suffix_opdec_chk
    import suffix_opdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] inst_word,
    input logic [WORD_W-1:0] next_word,
    input logic              next_valid,
    input logic [XLEN-1:0]   cur_ip,
    input logic              dec_valid,
    input logic              dec_nop,
    input logic              dec_stall,
    input logic              sfx_used,
    input logic              opa_is_const,
    input logic [SPEC_W-1:0] opa_reg,
    input logic [XLEN-1:0]   opa_value,
    input logic              opb_is_const,
    input logic [SPEC_W-1:0] opb_reg,
    input logic [XLEN-1:0]   opb_value
);
    localparam int TAG_LSB = WORD_W - TAG_W;
    localparam int RA_LSB  = TAG_LSB - SPEC_W;

    logic is_imm_sfx_ok;
    logic not_sfx_word;
    logic [SPEC_W-1:0] ra;

    // Input-side conditions used as antecedents below.
    always_comb begin
        not_sfx_word  = inst_word[TAG_LSB +: TAG_W] != TAG_SFX;
        ra            = inst_word[RA_LSB +: SPEC_W];
        is_imm_sfx_ok = (inst_word[TAG_LSB +: TAG_W] == TAG_IMM) && inst_word[IMM_W]
                        && next_valid && (next_word[TAG_LSB +: TAG_W] == TAG_SFX);
    end

    // R7
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> !dec_valid && !sfx_used && !opa_is_const && !opb_is_const);

    // R8
    nop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_nop |-> dec_valid && !opa_is_const && !opb_is_const && opa_reg == '0 && opb_reg == '0);

    // R6
    suffix_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_imm_sfx_ok |=> sfx_used && opb_is_const
            && opb_value[HI_W-1+IMM_W:IMM_W] == $past(next_word[HI_W-1:0]));

    // R3
    zero_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && not_sfx_word && ra == SPEC_ZERO && !(is_imm_sfx_ok == 1'b0 && inst_word[TAG_LSB +: TAG_W] == TAG_IMM && inst_word[IMM_W] && !next_valid)
        |=> opa_is_const && opa_value == '0);

    // R4
    ip_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && not_sfx_word && ra == SPEC_IP && !(inst_word[TAG_LSB +: TAG_W] == TAG_IMM && inst_word[IMM_W] && !next_valid)
        |=> opa_is_const && opa_value == $past(cur_ip));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid && !dec_stall && !dec_nop && !sfx_used);
endmodule

bind suffix_opdec suffix_opdec_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .inst_word    (inst_word),
    .next_word    (next_word),
    .next_valid   (next_valid),
    .cur_ip       (cur_ip),
    .dec_valid    (dec_valid),
    .dec_nop      (dec_nop),
    .dec_stall    (dec_stall),
    .sfx_used     (sfx_used),
    .opa_is_const (opa_is_const),
    .opa_reg      (opa_reg),
    .opa_value    (opa_value),
    .opb_is_const (opb_is_const),
    .opb_reg      (opb_reg),
    .opb_value    (opb_value)
);

// File: tb/suffix_opdec_tb_top.sv
// Scoreboard bench: the driver queues the expected result of each vector,
// the monitor compares it with the outputs just after the capturing edge.
module suffix_opdec_tb_top;
    localparam int W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [W-1:0] inst_word = '0;
    logic [W-1:0] next_word = '0;
    logic        next_valid = 1'b0;
    logic [63:0] cur_ip = '0;
    logic        dec_valid, dec_nop, dec_stall, sfx_used;
    logic        opa_is_const, opb_is_const;
    logic [5:0]  opa_reg, opb_reg;
    logic [63:0] opa_value, opb_value;

    typedef struct {
        logic [3:0]  flags;
        logic        a_c;
        logic [5:0]  a_r;
        logic [63:0] a_v;
        logic        b_c;
        logic [5:0]  b_r;
        logic [63:0] b_v;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    suffix_opdec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inst_word(inst_word),
        .next_word(next_word), .next_valid(next_valid), .cur_ip(cur_ip),
        .dec_valid(dec_valid), .dec_nop(dec_nop), .dec_stall(dec_stall),
        .sfx_used(sfx_used), .opa_is_const(opa_is_const), .opa_reg(opa_reg),
        .opa_value(opa_value), .opb_is_const(opb_is_const), .opb_reg(opb_reg),
        .opb_value(opb_value)
    );

    function automatic logic [W-1:0] mk_reg(logic [5:0] ra, logic [5:0] rb);
        return {4'h1, ra, rb, 24'h0};
    endfunction
    function automatic logic [W-1:0] mk_imm(logic [5:0] ra, logic flag, logic [27:0] imm);
        return {4'hE, ra, 1'b0, flag, imm};
    endfunction
    function automatic logic [W-1:0] mk_sfx(logic [35:0] p);
        return {4'hF, p};
    endfunction

    // Driver: present one vector and queue its expected result.
    // flags = {valid, nop, stall, sfx_used}
    task automatic drive(input logic v, input logic [W-1:0] iw, input logic [W-1:0] nw,
                         input logic nv, input logic [63:0] ip, input logic [3:0] fl,
                         input logic ac, input logic [5:0] ar, input logic [63:0] av,
                         input logic bc, input logic [5:0] br, input logic [63:0] bv,
                         input string req);
        exp_t e;
        @(negedge clk);
        in_valid = v; inst_word = iw; next_word = nw; next_valid = nv; cur_ip = ip;
        e.flags = fl; e.a_c = ac; e.a_r = ar; e.a_v = av;
        e.b_c = bc; e.b_r = br; e.b_v = bv; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs just after each capturing edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] got;
            e = exp_q.pop_front();
            got = {dec_valid, dec_nop, dec_stall, sfx_used};
            n_checks++;
            if (got !== e.flags || opa_is_const !== e.a_c || opa_reg !== e.a_r ||
                opa_value !== e.a_v || opb_is_const !== e.b_c || opb_reg !== e.b_r ||
                opb_value !== e.b_v) begin
                n_fail++;
                $display("FAIL %s: got flags=%b a=%b/%0d/%h b=%b/%0d/%h exp flags=%b a=%b/%0d/%h b=%b/%0d/%h",
                         e.req, got, opa_is_const, opa_reg, opa_value,
                         opb_is_const, opb_reg, opb_value,
                         e.flags, e.a_c, e.a_r, e.a_v, e.b_c, e.b_r, e.b_v);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [63:0] IP0 = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] IP1 = 64'h0000_0000_0040_1000;

    initial begin
        // R1: reset dominates a valid word on the inputs
        @(negedge clk);
        in_valid = 1'b1; inst_word = mk_reg(6'd62, 6'd7); cur_ip = IP0;
        @(negedge clk);
        exp_q.push_back('{4'b0000, 0, 0, 0, 0, 0, 0, "R1"});
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        // R11: idle input, junk word ignored
        drive(0, mk_imm(6'd63, 1, 28'h1), mk_sfx(36'h1), 1, IP0,
              4'b0000, 0, 0, 0, 0, 0, 0, "R11");
        // R2: plain register specifiers, boundaries 0 and 61
        drive(1, mk_reg(6'd5, 6'd61), '0, 0, IP0,
              4'b1000, 0, 6'd5, 0, 0, 6'd61, 0, "R2");
        drive(1, mk_reg(6'd0, 6'd33), '0, 0, IP0,
              4'b1000, 0, 6'd0, 0, 0, 6'd33, 0, "R2");
        // R3: zero specifier in A, register in B; then zero in B
        drive(1, mk_reg(6'd63, 6'd0), '0, 0, IP0,
              4'b1000, 1, 0, 0, 0, 6'd0, 0, "R3");
        drive(1, mk_reg(6'd9, 6'd63), '0, 0, IP0,
              4'b1000, 0, 6'd9, 0, 1, 0, 0, "R3");
        // R4: pointer specifier in both positions, two pointers back to back
        drive(1, mk_reg(6'd62, 6'd62), '0, 0, IP0,
              4'b1000, 1, 0, IP0, 1, 0, IP0, "R4");
        drive(1, mk_reg(6'd62, 6'd1), '0, 0, IP1,
              4'b1000, 1, 0, IP1, 0, 6'd1, 0, "R4");
        // R5: sign extension at positive and negative limits
        drive(1, mk_imm(6'd3, 0, 28'h7FF_FFFF), '0, 0, IP0,
              4'b1000, 0, 6'd3, 0, 1, 0, 64'h0000_0000_07FF_FFFF, "R5");
        drive(1, mk_imm(6'd4, 0, 28'h800_0000), '0, 0, IP0,
              4'b1000, 0, 6'd4, 0, 1, 0, 64'hFFFF_FFFF_F800_0000, "R5");
        // R6: suffix widens the immediate
        drive(1, mk_imm(6'd2, 1, 28'hABC_DEF1), mk_sfx(36'h9_8765_4321), 1, IP0,
              4'b1001, 0, 6'd2, 0, 1, 0, 64'h9876_5432_1ABC_DEF1, "R6");
        // R6 with R4: pointer in A and widened constant in B together
        drive(1, mk_imm(6'd62, 1, 28'h800_0000), mk_sfx(36'h0_0000_0001), 1, IP1,
              4'b1001, 1, 0, IP1, 1, 0, 64'h0000_0000_1800_0000, "R6");
        // R3 in immediate form
        drive(1, mk_imm(6'd63, 0, 28'h000_0010), '0, 0, IP0,
              4'b1000, 1, 0, 0, 1, 0, 64'h10, "R3");
        // R7: suffix needed but next word absent
        drive(1, mk_imm(6'd62, 1, 28'h123_4567), mk_sfx(36'hF_FFFF_FFFF), 0, IP0,
              4'b0010, 0, 0, 0, 0, 0, 0, "R7");
        // R8: lone suffix word at the slot
        drive(1, mk_sfx(36'h3_E000_0062), mk_sfx(36'h1), 1, IP0,
              4'b1100, 0, 0, 0, 0, 0, 0, "R8");
        // R9: flag set, next valid but wrong tag
        drive(1, mk_imm(6'd8, 1, 28'h800_0001), {4'h3, 36'hF_FFFF_FFFF}, 1, IP0,
              4'b1000, 0, 6'd8, 0, 1, 0, 64'hFFFF_FFFF_F800_0001, "R9");
        // R10: flag clear, next word is a valid suffix, must be ignored
        drive(1, mk_imm(6'd10, 0, 28'h000_0123), mk_sfx(36'hA_AAAA_AAAA), 1, IP0,
              4'b1000, 0, 6'd10, 0, 1, 0, 64'h123, "R10");
        // R11: back to idle after activity
        drive(0, mk_reg(6'd1, 6'd2), '0, 0, IP0,
              4'b0000, 0, 0, 0, 0, 0, 0, "R11");
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule